// File: doc/BRIEF.md
# Register Transfer Instruction Executor

This block executes the single-cycle data-movement instructions of an 8-bit controller core that has thirty-two general registers. Each cycle it can accept one 16-bit instruction word, qualified by a valid strobe. It decodes the word and carries out one of five operations:

- copy one register to another;
- copy an even/odd register pair to another pair;
- load an 8-bit constant into one of the upper sixteen registers;
- read a location of a 64-byte I/O space into a register;
- write a register to a location of the I/O space.

The block holds both the 32 x 8 register file and the 64 x 8 I/O array. Every operation finishes in the cycle it is presented. No condition flag is read or written.

Each I/O access is shown on the block's outputs while the instruction is being executed: the address, the write strobe, the write data and the current content of the addressed location. A write from a register therefore also serves as the normal way to observe a register's value. A word that matches none of the five layouts raises an illegal flag during its cycle and changes nothing.

Top module: `xfer_exec`

## Requirements
- R1: While `rst_n` is low at a rising edge, all 32 registers and all 64 I/O locations become zero.
- R2: A word whose top six bits are `001011` copies register `{w[9],w[3:0]}` into register `w[8:4]`, using any of the registers 0 to 31 as source or destination.
- R3: A word whose top byte is `0x01` copies register `2*w[3:0]` into register `2*w[7:4]` and register `2*w[3:0]+1` into register `2*w[7:4]+1`. Both copies take place at the same edge, and both use the values held before that edge.
- R4: A word whose top nibble is `0xE` writes the constant `{w[11:8],w[3:0]}` into register `16+w[7:4]`.
- R5: A word whose top five bits are `10110` copies I/O location `{w[10:9],w[3:0]}` into register `w[8:4]`. During that cycle `io_addr` shows the location and `io_rdata` shows its content.
- R6: A word whose top five bits are `10111` writes register `w[8:4]` into I/O location `{w[10:9],w[3:0]}` at the edge. During that cycle `io_we` is 1, `io_addr` shows the location and `io_wdata` shows the register value.
- R7: A valid word outside the five layouts drives `illegal` to 1 for that cycle only. It leaves `io_we` at 0 and changes no register and no I/O location.
- R8: With `instr_valid` low, `illegal` and `io_we` are 0 and no state changes, whatever value `instr` holds.
- R9: A value written at one edge is the operand seen by the instruction in the very next cycle, so a chain of dependent transfers runs back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change takes place on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Qualifies `instr` for the current cycle |
| instr | input | 16 | Instruction word to execute |
| io_addr | output | 6 | I/O location addressed by the current word |
| io_we | output | 1 | High while a register-to-I/O write is executing |
| io_wdata | output | 8 | Register value being written to the I/O space |
| io_rdata | output | 8 | Current content of the location at `io_addr` |
| illegal | output | 1 | High for a cycle whose valid word is unsupported |

## Verification
The I/O outputs and the illegal flag depend combinationally on the word being executed, so they are due in the same cycle it is driven. Register and I/O updates become visible from the following cycle, through a later write to the I/O space or through `io_rdata`. The driver changes the word at the falling edge and pushes the expected outputs, which it computes from a reference model that it updates in program order. One nanosecond later, still before the rising edge that commits the instruction, the monitor pops the entry and compares it. Register contents are observed by issuing I/O writes, and I/O contents by issuing reads, so every check is made through the block's ports.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
// Package xfer_pkg
// Shared sizes and the decoded-instruction record used by the transfer
// executor. Assumes an 8-bit datapath, 32 registers and a 64-entry I/O space.
package xfer_pkg;

    localparam int DATA_W  = 8;
    localparam int NREG    = 32;
    localparam int NIO     = 64;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int IOA_W   = $clog2(NIO);
    localparam int INSTR_W = 16;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_MOV  = 3'd1,
        OP_PAIR = 3'd2,
        OP_LDK  = 3'd3,
        OP_IORD = 3'd4,
        OP_IOWR = 3'd5,
        OP_BAD  = 3'd6
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [RIDX_W-1:0]  dst;
        logic [RIDX_W-1:0]  src;
        logic [DATA_W-1:0]  imm;
        logic [IOA_W-1:0]   ioa;
    } dec_t;

endpackage

// File: rtl/xfer_decode.sv
`timescale 1ns/1ps
// Module xfer_decode
// Purely combinational decoder. It splits a 16-bit word into an operation,
// register indices, an 8-bit constant and an I/O address. Operand bits that
// lie scattered in the word are gathered here. Assumes one word per cycle;
// the valid strobe selects between idle and a real decode.
module xfer_decode
    import xfer_pkg::*;
(
    input  logic               valid,
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);

    localparam logic [5:0] PFX_MOV  = 6'b001011;
    localparam logic [7:0] PFX_PAIR = 8'b0000_0001;
    localparam logic [3:0] PFX_LDK  = 4'b1110;
    localparam logic [4:0] PFX_IORD = 5'b10110;
    localparam logic [4:0] PFX_IOWR = 5'b10111;

    logic hit_mov, hit_pair, hit_ldk, hit_iord, hit_iowr;

    // Match each fixed opcode prefix.
    always_comb begin
        hit_mov  = (word[15:10] == PFX_MOV);
        hit_pair = (word[15:8]  == PFX_PAIR);
        hit_ldk  = (word[15:12] == PFX_LDK);
        hit_iord = (word[15:11] == PFX_IORD);
        hit_iowr = (word[15:11] == PFX_IOWR);
    end

    // Choose the operation and gather its operand fields.
    always_comb begin
        dec      = '0;
        dec.op   = OP_IDLE;
        dec.imm  = {word[11:8], word[3:0]};
        dec.ioa  = {word[10:9], word[3:0]};
        if (valid) begin
            if (hit_mov) begin
                dec.op  = OP_MOV;
                dec.dst = word[8:4];
                dec.src = {word[9], word[3:0]};
            end else if (hit_pair) begin
                dec.op  = OP_PAIR;
                dec.dst = {word[7:4], 1'b0};
                dec.src = {word[3:0], 1'b0};
            end else if (hit_ldk) begin
                dec.op  = OP_LDK;
                dec.dst = {1'b1, word[7:4]};
            end else if (hit_iord) begin
                dec.op  = OP_IORD;
                dec.dst = word[8:4];
            end else if (hit_iowr) begin
                dec.op  = OP_IOWR;
                dec.src = word[8:4];
            end else begin
                dec.op  = OP_BAD;
            end
        end
    end

endmodule

// File: rtl/xfer_regfile.sv
`timescale 1ns/1ps
// Module xfer_regfile
// General register file with two combinational read ports and two write
// ports. The second write port serves the odd half of a pair copy. Assumes
// the two write indices never collide; the executor drives port B only for
// pair copies, where its index is odd and port A's is even.
module xfer_regfile
    import xfer_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = DATA_W,
    localparam int IW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic          wa_en,
    input  logic [IW-1:0] wa_idx,
    input  logic [W-1:0]  wa_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [W-1:0]  wb_data
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Hold one register; port A wins if both ports ever aim at it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wa_en && wa_idx == IW'(g))
                regs[g] <= wa_data;
            else if (wb_en && wb_idx == IW'(g))
                regs[g] <= wb_data;
        end
    end

    // Read both operand ports.
    always_comb begin
        ra_data = regs[ra_idx];
        rb_data = regs[rb_idx];
    end

endmodule

// File: rtl/xfer_ioarray.sv
`timescale 1ns/1ps
// Module xfer_ioarray
// Byte-wide I/O location array with one write port and one combinational
// read port at the same address. A write lands at the edge, so a read of
// the same address shows the new value from the following cycle.
module xfer_ioarray
    import xfer_pkg::*;
#(
    parameter int N = NIO,
    parameter int W = DATA_W,
    localparam int AW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] loc [N];

    for (genvar g = 0; g < N; g++) begin : g_loc
        // Hold one location, loading it on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                loc[g] <= '0;
            else if (we && addr == AW'(g))
                loc[g] <= wdata;
        end
    end

    // Present the addressed location.
    always_comb rdata = loc[addr];

endmodule

// File: rtl/xfer_exec.sv
`timescale 1ns/1ps
// Module xfer_exec
// Top of the transfer executor. It decodes the word, reads the operands,
// selects the write-back source and drives the I/O array. All side effects
// commit at one rising edge, so each instruction takes exactly one cycle.
// Assumes no stall: a valid word is executed in the cycle it is presented.
module xfer_exec
    import xfer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    output logic [IOA_W-1:0]    io_addr,
    output logic                io_we,
    output logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    output logic                illegal
);

    dec_t              dec;
    logic [DATA_W-1:0] opa, opb;
    logic              wa_en, wb_en;
    logic [RIDX_W-1:0] wb_idx, rb_idx;
    logic [DATA_W-1:0] wa_data;

    xfer_decode u_dec (
        .valid (instr_valid),
        .word  (instr),
        .dec   (dec)
    );

    // Odd partners of the even pair indices.
    always_comb begin
        rb_idx = {dec.src[RIDX_W-1:1], 1'b1};
        wb_idx = {dec.dst[RIDX_W-1:1], 1'b1};
    end

    // Select what lands in the destination register.
    always_comb begin
        wa_en   = 1'b0;
        wb_en   = 1'b0;
        wa_data = opa;
        unique case (dec.op)
            OP_MOV:  wa_en = 1'b1;
            OP_PAIR: begin
                wa_en = 1'b1;
                wb_en = 1'b1;
            end
            OP_LDK: begin
                wa_en   = 1'b1;
                wa_data = dec.imm;
            end
            OP_IORD: begin
                wa_en   = 1'b1;
                wa_data = io_rdata;
            end
            default: ;
        endcase
    end

    // Drive the I/O side and the illegal flag.
    always_comb begin
        io_addr  = dec.ioa;
        io_we    = (dec.op == OP_IOWR);
        io_wdata = opa;
        illegal  = (dec.op == OP_BAD);
    end

    xfer_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (dec.src),
        .ra_data (opa),
        .rb_idx  (rb_idx),
        .rb_data (opb),
        .wa_en   (wa_en),
        .wa_idx  (dec.dst),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_data (opb)
    );

    xfer_ioarray u_io (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (io_addr),
        .we    (io_we),
        .wdata (io_wdata),
        .rdata (io_rdata)
    );

endmodule

// File: rtl/xfer_exec_chk.sv
`timescale 1ns/1ps
// Module xfer_exec_chk
// Port-level properties of the transfer executor, attached by bind.
module xfer_exec_chk
    import xfer_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                instr_valid,
    input logic [INSTR_W-1:0]  instr,
    input logic [IOA_W-1:0]    io_addr,
    input logic                io_we,
    input logic [DATA_W-1:0]   io_wdata,
    input logic [DATA_W-1:0]   io_rdata,
    input logic                illegal
);

    logic armed;

    // Mark cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_io_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> io_rdata == '0);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (!io_we && !illegal));

    a_r7_illegal_valid: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> instr_valid);

    a_r7_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !io_we);

    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(io_we) && io_addr == $past(io_addr))
            |-> io_rdata == $past(io_wdata));

    a_r5_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(io_we) && io_addr == $past(io_addr))
            |-> $stable(io_rdata));

endmodule

bind xfer_exec xfer_exec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .io_addr     (io_addr),
    .io_we       (io_we),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .illegal     (illegal)
);

// File: tb/sim_xfer_exec.sv
`timescale 1ns/1ps
module sim_xfer_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [5:0]  io_addr;
    logic        io_we;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xfer_exec u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .illegal(illegal)
    );

    typedef struct {
        logic       we;
        logic [5:0] addr;
        logic [7:0] wdata;
        logic       ill;
        logic       rchk;
        logic [7:0] rdata;
        string      tag;
    } exp_t;

    exp_t      q[$];
    logic [7:0] m_reg [32];
    logic [7:0] m_io  [64];

    function automatic logic [15:0] e_mov(int d, int r);
        return {6'b001011, 1'(r >> 4), 5'(d), 4'(r)};
    endfunction
    function automatic logic [15:0] e_pair(int d, int r);
        return {8'h01, 4'(d / 2), 4'(r / 2)};
    endfunction
    function automatic logic [15:0] e_ldk(int d, int k);
        return {4'hE, 4'(k >> 4), 4'(d - 16), 4'(k)};
    endfunction
    function automatic logic [15:0] e_in(int d, int a);
        return {5'b10110, 2'(a >> 4), 5'(d), 4'(a)};
    endfunction
    function automatic logic [15:0] e_out(int a, int r);
        return {5'b10111, 2'(a >> 4), 5'(r), 4'(a)};
    endfunction

    function automatic void chk(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endfunction

    // Driver: present one cycle of stimulus and queue its expected outputs.
    task automatic step(bit v, logic [15:0] w, string tag);
        exp_t e;
        logic [7:0] t0, t1;
        int d, r, a;
        e.we = 0; e.addr = 0; e.wdata = 0; e.ill = 0; e.rchk = 0; e.rdata = 0;
        e.tag = tag;
        @(negedge clk);
        instr_valid = v;
        instr = w;
        if (v) begin
            a = {w[10:9], w[3:0]};
            if (w[15:10] == 6'b001011) begin
                d = w[8:4]; r = {w[9], w[3:0]};
                m_reg[d] = m_reg[r];
            end else if (w[15:8] == 8'h01) begin
                d = 2 * w[7:4]; r = 2 * w[3:0];
                t0 = m_reg[r]; t1 = m_reg[r+1];
                m_reg[d] = t0; m_reg[d+1] = t1;
            end else if (w[15:12] == 4'hE) begin
                m_reg[16 + w[7:4]] = {w[11:8], w[3:0]};
            end else if (w[15:11] == 5'b10110) begin
                e.rchk = 1; e.addr = 6'(a); e.rdata = m_io[a];
                m_reg[w[8:4]] = m_io[a];
            end else if (w[15:11] == 5'b10111) begin
                e.we = 1; e.addr = 6'(a); e.wdata = m_reg[w[8:4]];
                m_io[a] = m_reg[w[8:4]];
            end else begin
                e.ill = 1;
            end
        end
        q.push_back(e);
    endtask

    // Monitor: compare each queued item before the committing edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(io_we === e.we, e.tag, "io_we", int'(io_we), int'(e.we));
                chk(illegal === e.ill, e.tag, "illegal", int'(illegal), int'(e.ill));
                if (e.we || e.rchk)
                    chk(io_addr === e.addr, e.tag, "io_addr", int'(io_addr), int'(e.addr));
                if (e.we)
                    chk(io_wdata === e.wdata, e.tag, "io_wdata", int'(io_wdata), int'(e.wdata));
                if (e.rchk)
                    chk(io_rdata === e.rdata, e.tag, "io_rdata", int'(io_rdata), int'(e.rdata));
            end
        end
    end

    task automatic dump_regs(string tag);
        for (int i = 0; i < 32; i++) step(1, e_out(i, i), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) m_reg[i] = 8'hxx;
        for (int i = 0; i < 64; i++) m_io[i] = 8'hxx;
        repeat (3) @(negedge clk);
        // R1: reset clears everything
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 32; i++) m_reg[i] = 0;
        for (int i = 0; i < 64; i++) m_io[i] = 0;
        for (int a = 0; a < 64; a++) step(1, e_in(a % 32, a), "R1");
        dump_regs("R1");

        // R4: constants into every upper register, nibble order
        for (int d = 16; d < 32; d++) step(1, e_ldk(d, (d * 37 + 5) & 8'hFF), "R4");
        step(1, e_ldk(31, 8'hA5), "R4");
        step(1, e_ldk(16, 8'h3C), "R4");
        dump_regs("R4");

        // R2: copies across the whole index range, both source halves
        step(1, e_mov(0, 31), "R2");
        step(1, e_mov(15, 16), "R2");
        step(1, e_mov(1, 17), "R2");
        step(1, e_mov(30, 0), "R2");
        step(1, e_mov(5, 5), "R2");
        dump_regs("R2");

        // R3: pair copies, including overlapping pairs
        step(1, e_pair(2, 30), "R3");
        step(1, e_pair(30, 16), "R3");
        step(1, e_pair(0, 0), "R3");
        step(1, e_pair(18, 2), "R3");
        dump_regs("R3");

        // R6 / R5: writes to edge addresses, then read them back
        step(1, e_out(0, 31), "R6");
        step(1, e_out(63, 17), "R6");
        step(1, e_out(42, 20), "R6");
        step(1, e_out(21, 0), "R6");
        step(1, e_in(3, 63), "R5");
        step(1, e_in(4, 0), "R5");
        step(1, e_in(6, 42), "R5");
        step(1, e_in(31, 21), "R5");
        dump_regs("R5");

        // R7: unsupported words change nothing
        step(1, 16'h0000, "R7");
        step(1, 16'hFFFF, "R7");
        step(1, 16'h9000, "R7");
        step(1, 16'h0200, "R7");
        step(1, 16'h2C00 ^ 16'h0400, "R7");
        step(1, 16'hC123, "R7");
        dump_regs("R7");
        for (int a = 0; a < 64; a += 7) step(1, e_in(8, a), "R7");

        // R8: invalid cycles with transfer-looking words do nothing
        step(0, e_out(5, 31), "R8");
        step(0, e_ldk(20, 8'h77), "R8");
        step(0, 16'hFFFF, "R8");
        step(0, e_mov(0, 1), "R8");
        step(1, e_in(9, 5), "R8");
        dump_regs("R8");

        // R9: dependent chain, each step uses the previous result
        step(1, e_ldk(24, 8'h5A), "R9");
        step(1, e_mov(3, 24), "R9");
        step(1, e_out(10, 3), "R9");
        step(1, e_in(25, 10), "R9");
        step(1, e_pair(12, 24), "R9");
        step(1, e_out(11, 13), "R9");

        // R9: mixed random stream
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 6);
            case (k)
                0: step(1, e_mov($urandom_range(0, 31), $urandom_range(0, 31)), "R9");
                1: step(1, e_pair(2 * $urandom_range(0, 15), 2 * $urandom_range(0, 15)), "R9");
                2: step(1, e_ldk($urandom_range(16, 31), $urandom_range(0, 255)), "R9");
                3: step(1, e_in($urandom_range(0, 31), $urandom_range(0, 63)), "R9");
                4: step(1, e_out($urandom_range(0, 63), $urandom_range(0, 31)), "R9");
                5: step(0, 16'($urandom), "R8");
                default: step(1, e_out($urandom_range(0, 63), $urandom_range(0, 31)), "R9");
            endcase
        end
        dump_regs("R9");

        step(0, 16'h0000, "R8");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule